// File: doc/BRIEF.md
# Sectored Key-Addressed Object Store

A small local store placed between a group of compute lanes and a shared last-level cache. Lanes never form addresses: they name a data-structure element by a key and a sector number, and the store finds the entry whose key tag matches. One key tag covers a whole line of several sectors. Every sector carries its own valid and dirty bit, so a line can be partly present, and a vector spread over a line costs a single tag.

Before an iteration, a collector allocates entries and fills them in bulk with a sector mask. During the iteration, lanes load and store sectors by key. A load that finds no valid sector raises a miss and waits while the collector refills that one sector from the cache. When the iteration ends, a flush walks the entries in ascending order. It sends every dirty sector to the cache, tagged with the line pointer kept in the entry, so no reverse translation is needed. It then frees every entry. Entries are never evicted while an iteration holds them. When no entry is free, allocation is refused and a full flag is shown to the collector.

Top module: `osx_store`

## Requirements
- R1: After reset, fill_full, lane_ack, lane_miss, wb_valid, flush_busy and flush_done are all 0, and every entry is free.
- R2: When fill_valid is high and fill_full is low, the lowest-numbered free entry takes fill_key, fill_line and the sectors of fill_data. Sector s is bits [s*SECTOR_W +: SECTOR_W]. Sector s becomes valid and clean when bit s of fill_mask is 1, and invalid otherwise.
- R3: fill_full is 1 while all ENTRIES entries are in use or a flush is running. An allocation offered while fill_full is 1 changes nothing: a later load of its key misses.
- R4: A lane load (lane_req=1, lane_we=0) whose key matches an entry whose addressed sector is valid gives lane_ack=1, lane_miss=0 and lane_rdata equal to that sector's data in the next cycle.
- R5: A lane load whose key matches no entry, or whose addressed sector is invalid, gives lane_miss=1 and lane_ack=0 in the next cycle.
- R6: A refill (refill_valid=1) whose key matches an entry writes refill_data into sector refill_sec, and marks that sector valid and clean. A load of that sector then hits. A refill with a key that matches no entry has no effect.
- R7: A lane store (lane_we=1) whose key matches an entry writes lane_wdata into the addressed sector and marks it valid and dirty, with lane_ack=1 in the next cycle. A store to an unknown key gives lane_miss=1 and writes nothing.
- R8: A flush_start pulse while idle raises flush_busy. Entries are then visited in ascending index. Each dirty sector of an entry is presented on wb_valid in ascending sector order, with wb_line = that entry's line pointer, wb_sec and wb_data. Each beat is held until wb_ready is 1. Clean sectors produce no beat.
- R9: After the last entry is visited, flush_busy falls and flush_done is 1 for exactly one cycle, the first cycle with flush_busy low. At that point no entry is in use and no sector is dirty.
- R10: While flush_busy is 1, lane requests, refills and allocations are ignored: the next cycle shows lane_ack=0 and lane_miss=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fill_valid | input | 1 | Bulk allocation request |
| fill_key | input | KEY_W | Key tag of the new entry |
| fill_line | input | LINE_W | Last-level cache line pointer of the new entry |
| fill_mask | input | SECTORS | Sectors supplied by the bulk fill |
| fill_data | input | SECTORS*SECTOR_W | Sector data, sector s at bits s*SECTOR_W |
| fill_full | output | 1 | Allocation refused (no free entry or flush running) |
| refill_valid | input | 1 | Single-sector refill |
| refill_key | input | KEY_W | Key of the refilled entry |
| refill_sec | input | log2(SECTORS) | Refilled sector |
| refill_data | input | SECTOR_W | Refill data |
| lane_req | input | 1 | Lane access request |
| lane_we | input | 1 | 1 = store, 0 = load |
| lane_key | input | KEY_W | Element key |
| lane_sec | input | log2(SECTORS) | Sector within the entry |
| lane_wdata | input | SECTOR_W | Store data |
| lane_ack | output | 1 | Access completed (one cycle after request) |
| lane_miss | output | 1 | Access missed (one cycle after request) |
| lane_rdata | output | SECTOR_W | Load data |
| flush_start | input | 1 | End-of-iteration writeback request |
| flush_busy | output | 1 | Flush in progress |
| flush_done | output | 1 | One-cycle pulse when the flush completes |
| wb_valid | output | 1 | Writeback beat offered |
| wb_ready | input | 1 | Cache accepts the beat |
| wb_line | output | LINE_W | Line pointer of the beat |
| wb_sec | output | log2(SECTORS) | Sector of the beat |
| wb_data | output | SECTOR_W | Sector data of the beat |

## Verification
The hardest situation to reach is a flush that has to order dirty sectors from several entries while the cache is stalling it. It must skip clean and refilled sectors, and it must ignore a lane request that arrives in the middle. To get there, the bench fills every entry, which also drives the store into the full state. Each entry gets one of two sector masks, and a sweep of every key and sector then confirms the exact hit and miss pattern. Stores are then placed in scattered entries and sectors, including one into an invalid sector. The flush runs against a wb_ready that alternates after an initial stall, and each beat is compared with an ordered list that the bench derives from the stores it issued.

// File: rtl/osx_pkg.sv
package osx_pkg;
   // flush controller states
   typedef enum logic {
      FL_IDLE = 1'b0,
      FL_WALK = 1'b1
   } flush_state_e;
endpackage

// File: rtl/osx_prio_enc.sv
module osx_prio_enc #(
   parameter int N = 8,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [IW-1:0] idx,
   output logic          any
);
   generate
      if (N < 2) begin : g_bad_n
         $error("osx_prio_enc: N must be at least 2");
      end
   endgenerate

   // lowest set bit wins
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
      any = |req;
   end
endmodule

// File: rtl/osx_key_match.sv
module osx_key_match #(
   parameter int ENTRIES = 16,
   parameter int KEY_W   = 16
) (
   input  logic [ENTRIES-1:0]       used,
   input  logic [ENTRIES*KEY_W-1:0] tags,
   input  logic [KEY_W-1:0]         key,
   output logic [ENTRIES-1:0]       hit
);
   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
         assign hit[e] = used[e] && (tags[e*KEY_W +: KEY_W] == key);
      end
   endgenerate
endmodule

// File: rtl/osx_flush_ctrl.sv
module osx_flush_ctrl
   import osx_pkg::*;
#(
   parameter int ENTRIES = 16,
   localparam int EIW = $clog2(ENTRIES)
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           start,
   input  logic           cur_dirty,
   output logic           busy,
   output logic           done,
   output logic           advance,
   output logic [EIW-1:0] ptr
);
   localparam logic [EIW-1:0] LAST = EIW'(ENTRIES - 1);

   flush_state_e state_q;

   assign busy    = (state_q == FL_WALK);
   assign advance = busy && !cur_dirty;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= FL_IDLE;
         ptr     <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state_q)
            FL_IDLE: begin
               if (start) begin
                  state_q <= FL_WALK;
                  ptr     <= '0;
               end
            end
            FL_WALK: begin
               if (advance) begin
                  if (ptr == LAST) begin
                     state_q <= FL_IDLE;
                     done    <= 1'b1;
                  end else begin
                     ptr <= ptr + 1'b1;
                  end
               end
            end
            default: state_q <= FL_IDLE;
         endcase
      end
   end

   // R8
   ptr_order_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy)) |-> (ptr >= $past(ptr)));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
endmodule

// File: rtl/osx_store.sv
module osx_store
   import osx_pkg::*;
#(
   parameter int ENTRIES  = 16,
   parameter int SECTORS  = 8,
   parameter int SECTOR_W = 64,
   parameter int KEY_W    = 16,
   parameter int LINE_W   = 26,
   localparam int SIW = $clog2(SECTORS),
   localparam int EIW = $clog2(ENTRIES),
   localparam int LINE_BITS = SECTORS * SECTOR_W
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 fill_valid,
   input  logic [KEY_W-1:0]     fill_key,
   input  logic [LINE_W-1:0]    fill_line,
   input  logic [SECTORS-1:0]   fill_mask,
   input  logic [LINE_BITS-1:0] fill_data,
   output logic                 fill_full,
   input  logic                 refill_valid,
   input  logic [KEY_W-1:0]     refill_key,
   input  logic [SIW-1:0]       refill_sec,
   input  logic [SECTOR_W-1:0]  refill_data,
   input  logic                 lane_req,
   input  logic                 lane_we,
   input  logic [KEY_W-1:0]     lane_key,
   input  logic [SIW-1:0]       lane_sec,
   input  logic [SECTOR_W-1:0]  lane_wdata,
   output logic                 lane_ack,
   output logic                 lane_miss,
   output logic [SECTOR_W-1:0]  lane_rdata,
   input  logic                 flush_start,
   output logic                 flush_busy,
   output logic                 flush_done,
   output logic                 wb_valid,
   input  logic                 wb_ready,
   output logic [LINE_W-1:0]    wb_line,
   output logic [SIW-1:0]       wb_sec,
   output logic [SECTOR_W-1:0]  wb_data
);
   // elaboration-time parameter checks
   generate
      if (ENTRIES < 2 || (1 << EIW) != ENTRIES) begin : g_bad_entries
         $error("osx_store: ENTRIES must be a power of two, at least 2");
      end
      if (SECTORS < 2 || (1 << SIW) != SECTORS) begin : g_bad_sectors
         $error("osx_store: SECTORS must be a power of two, at least 2");
      end
      if (SECTOR_W < 8 || KEY_W < 1 || LINE_W < 1) begin : g_bad_widths
         $error("osx_store: field widths out of range");
      end
   endgenerate

   // entry state
   logic [ENTRIES-1:0]  used_q;
   logic [KEY_W-1:0]    key_q  [ENTRIES];
   logic [LINE_W-1:0]   line_q [ENTRIES];
   logic [SECTORS-1:0]  sv_q   [ENTRIES];
   logic [SECTORS-1:0]  sd_q   [ENTRIES];
   logic [SECTOR_W-1:0] data_q [ENTRIES][SECTORS];

   logic [ENTRIES*KEY_W-1:0]   tags_flat;
   logic [ENTRIES*SECTORS-1:0] sv_flat, sd_flat;

   always_comb begin
      for (int e = 0; e < ENTRIES; e++) begin
         tags_flat[e*KEY_W +: KEY_W]     = key_q[e];
         sv_flat[e*SECTORS +: SECTORS]   = sv_q[e];
         sd_flat[e*SECTORS +: SECTORS]   = sd_q[e];
      end
   end

   // lookups
   logic [ENTRIES-1:0] lane_hitv, refill_hitv;
   logic [EIW-1:0]     lane_idx, refill_idx, free_idx;
   logic               lane_any, refill_any, free_any;

   osx_key_match #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_lane_match (
      .used(used_q), .tags(tags_flat), .key(lane_key), .hit(lane_hitv));
   osx_key_match #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_refill_match (
      .used(used_q), .tags(tags_flat), .key(refill_key), .hit(refill_hitv));

   osx_prio_enc #(.N(ENTRIES)) u_lane_pe (
      .req(lane_hitv), .idx(lane_idx), .any(lane_any));
   osx_prio_enc #(.N(ENTRIES)) u_refill_pe (
      .req(refill_hitv), .idx(refill_idx), .any(refill_any));
   osx_prio_enc #(.N(ENTRIES)) u_free_pe (
      .req(~used_q), .idx(free_idx), .any(free_any));

   // flush walk
   logic           fl_adv;
   logic [EIW-1:0] fl_ptr;
   logic [SIW-1:0] dirty_sec;
   logic           dirty_any;

   osx_prio_enc #(.N(SECTORS)) u_dirty_pe (
      .req(sd_q[fl_ptr]), .idx(dirty_sec), .any(dirty_any));

   osx_flush_ctrl #(.ENTRIES(ENTRIES)) u_flush (
      .clk(clk), .rst(rst), .start(flush_start), .cur_dirty(dirty_any),
      .busy(flush_busy), .done(flush_done), .advance(fl_adv), .ptr(fl_ptr));

   assign wb_valid = flush_busy && dirty_any;
   assign wb_sec   = dirty_sec;
   assign wb_line  = line_q[fl_ptr];
   assign wb_data  = data_q[fl_ptr][dirty_sec];

   // admission
   logic do_alloc, do_refill, do_store, lane_hit, wb_fire;

   assign fill_full = flush_busy || !free_any;
   assign do_alloc  = fill_valid && !fill_full;
   assign do_refill = refill_valid && !flush_busy && refill_any;
   assign lane_hit  = lane_any && (lane_we || sv_q[lane_idx][lane_sec]);
   assign do_store  = lane_req && lane_we && !flush_busy && lane_any;
   assign wb_fire   = wb_valid && wb_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         used_q    <= '0;
         lane_ack  <= 1'b0;
         lane_miss <= 1'b0;
         for (int e = 0; e < ENTRIES; e++) begin
            sv_q[e]   <= '0;
            sd_q[e]   <= '0;
            key_q[e]  <= '0;
            line_q[e] <= '0;
         end
      end else begin
         lane_ack  <= lane_req && !flush_busy && lane_hit;
         lane_miss <= lane_req && !flush_busy && !lane_hit;
         if (do_alloc) begin
            used_q[free_idx] <= 1'b1;
            key_q[free_idx]  <= fill_key;
            line_q[free_idx] <= fill_line;
            sv_q[free_idx]   <= fill_mask;
            sd_q[free_idx]   <= '0;
            for (int s = 0; s < SECTORS; s++) begin
               data_q[free_idx][s] <= fill_data[s*SECTOR_W +: SECTOR_W];
            end
         end
         if (do_refill) begin
            data_q[refill_idx][refill_sec] <= refill_data;
            sv_q[refill_idx][refill_sec]   <= 1'b1;
            sd_q[refill_idx][refill_sec]   <= 1'b0;
         end
         if (do_store) begin
            data_q[lane_idx][lane_sec] <= lane_wdata;
            sv_q[lane_idx][lane_sec]   <= 1'b1;
            sd_q[lane_idx][lane_sec]   <= 1'b1;
         end
         if (wb_fire) begin
            sd_q[fl_ptr][dirty_sec] <= 1'b0;
         end
         if (fl_adv) begin
            used_q[fl_ptr] <= 1'b0;
            sv_q[fl_ptr]   <= '0;
            sd_q[fl_ptr]   <= '0;
         end
      end
   end

   // lane read data: sector contents before any same-cycle write
   always_ff @(posedge clk) begin
      lane_rdata <= data_q[lane_idx][lane_sec];
   end

   // R7
   dirty_valid_chk: assert property (@(posedge clk) disable iff (rst)
      (sd_flat & ~sv_flat) == '0);

   // R3
   full_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (fill_valid && fill_full && !flush_busy) |=>
         ($countones(used_q) == $past($countones(used_q))));

   // R8
   wb_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (wb_valid && !wb_ready) |=>
         (wb_valid && $stable(wb_sec) && $stable(wb_line) && $stable(wb_data)));

   // R9
   flush_clean_chk: assert property (@(posedge clk) disable iff (rst)
      flush_done |-> (used_q == '0 && sd_flat == '0 && !flush_busy));

   // R10
   quiet_chk: assert property (@(posedge clk) disable iff (rst)
      flush_busy |=> (!lane_ack && !lane_miss));

   // R4
   ack_miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(lane_ack && lane_miss));
endmodule

// File: tb/osx_store_bench.sv
module osx_store_bench;
   localparam int PERIOD   = 10;
   localparam int ENTRIES  = 16;
   localparam int SECTORS  = 8;
   localparam int SECTOR_W = 64;
   localparam int KEY_W    = 16;
   localparam int LINE_W   = 26;
   localparam int SIW      = 3;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic fill_valid = 0;
   logic [KEY_W-1:0] fill_key = '0;
   logic [LINE_W-1:0] fill_line = '0;
   logic [SECTORS-1:0] fill_mask = '0;
   logic [SECTORS*SECTOR_W-1:0] fill_data = '0;
   logic fill_full;
   logic refill_valid = 0;
   logic [KEY_W-1:0] refill_key = '0;
   logic [SIW-1:0] refill_sec = '0;
   logic [SECTOR_W-1:0] refill_data = '0;
   logic lane_req = 0, lane_we = 0;
   logic [KEY_W-1:0] lane_key = '0;
   logic [SIW-1:0] lane_sec = '0;
   logic [SECTOR_W-1:0] lane_wdata = '0;
   logic lane_ack, lane_miss;
   logic [SECTOR_W-1:0] lane_rdata;
   logic flush_start = 0, flush_busy, flush_done;
   logic wb_valid, wb_ready = 0;
   logic [LINE_W-1:0] wb_line;
   logic [SIW-1:0] wb_sec;
   logic [SECTOR_W-1:0] wb_data;

   osx_store #(.ENTRIES(ENTRIES), .SECTORS(SECTORS), .SECTOR_W(SECTOR_W),
               .KEY_W(KEY_W), .LINE_W(LINE_W)) u_osx_store (.*);

   always #(PERIOD/2) clk = ~clk;

   int n_run = 0, n_fail = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [SECTOR_W-1:0] sdat(input int e, input int s);
      return {32'hA5A5_0000 | 32'(e), 32'(s * 7 + 3)};
   endfunction

   // lane access: drive at negedge, sample one negedge later
   task automatic lane_op(input bit we, input logic [KEY_W-1:0] k,
                          input int s, input logic [SECTOR_W-1:0] wd);
      lane_req = 1; lane_we = we; lane_key = k; lane_sec = SIW'(s); lane_wdata = wd;
      @(negedge clk);
      lane_req = 0; lane_we = 0;
   endtask

   task automatic do_fill(input logic [KEY_W-1:0] k, input logic [LINE_W-1:0] ln,
                          input logic [SECTORS-1:0] m, input int e);
      fill_valid = 1; fill_key = k; fill_line = ln; fill_mask = m;
      for (int s = 0; s < SECTORS; s++) fill_data[s*SECTOR_W +: SECTOR_W] = sdat(e, s);
      @(negedge clk);
      fill_valid = 0;
   endtask

   // expected writeback beats
   logic [LINE_W-1:0]   exp_line [4];
   logic [SIW-1:0]      exp_sec  [4];
   logic [SECTOR_W-1:0] exp_dat  [4];

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      @(negedge clk);
      // R1 reset state
      chk(!fill_full && !lane_ack && !lane_miss, "R1 idle outputs", {62'd0, fill_full, lane_ack}, 0);
      chk(!wb_valid && !flush_busy && !flush_done, "R1 flush idle", {62'd0, wb_valid, flush_busy}, 0);

      // R2 fill every entry: even entries all sectors, odd entries sectors 0..3
      for (int e = 0; e < ENTRIES; e++) begin
         chk(!fill_full, "R3 not full before last fill", fill_full, 0);
         do_fill(KEY_W'(16'h100 + e), LINE_W'(26'h1000 + e),
                 (e % 2 == 0) ? 8'hFF : 8'h0F, e);
      end
      chk(fill_full, "R3 full after all entries", fill_full, 1);
      // refused allocation
      do_fill(16'h03FF, 26'h3FFF, 8'hFF, 99);
      lane_op(0, 16'h03FF, 0, 0);
      chk(lane_miss && !lane_ack, "R3 refused fill left no entry", lane_miss, 1);

      // R4 / R5 sweep of every key and sector
      for (int e = 0; e < ENTRIES; e++) begin
         for (int s = 0; s < SECTORS; s++) begin
            lane_op(0, KEY_W'(16'h100 + e), s, 0);
            if (e % 2 == 0 || s < 4) begin
               chk(lane_ack && !lane_miss, "R4 load hit flag", lane_ack, 1);
               chk(lane_rdata == sdat(e, s), "R2 R4 load data", lane_rdata, sdat(e, s));
            end else begin
               chk(lane_miss && !lane_ack, "R5 invalid sector miss", lane_miss, 1);
            end
         end
      end
      lane_op(0, 16'h0055, 2, 0);
      chk(lane_miss && !lane_ack, "R5 unknown key miss", lane_miss, 1);

      // R6 refill entry 1 sector 6
      lane_op(0, 16'h101, 6, 0);
      chk(lane_miss, "R6 miss before refill", lane_miss, 1);
      refill_valid = 1; refill_key = 16'h101; refill_sec = 3'd6; refill_data = 64'hCAFE_0001_0006;
      @(negedge clk);
      refill_valid = 0;
      lane_op(0, 16'h101, 6, 0);
      chk(lane_ack && lane_rdata == 64'hCAFE_0001_0006, "R6 refill then hit", lane_rdata, 64'hCAFE_0001_0006);
      refill_valid = 1; refill_key = 16'h0777; refill_sec = 3'd0; refill_data = 64'h1;
      @(negedge clk);
      refill_valid = 0;
      lane_op(0, 16'h0777, 0, 0);
      chk(lane_miss, "R6 refill unknown key ignored", lane_miss, 1);

      // R7 stores
      lane_op(1, 16'h100, 0, 64'hD000_0000); chk(lane_ack, "R7 store ack e0s0", lane_ack, 1);
      lane_op(1, 16'h102, 6, 64'hD000_0206); chk(lane_ack, "R7 store ack e2s6", lane_ack, 1);
      lane_op(1, 16'h102, 1, 64'hD000_0201); chk(lane_ack, "R7 store ack e2s1", lane_ack, 1);
      lane_op(1, 16'h105, 7, 64'hD000_0507); chk(lane_ack, "R7 store to invalid sector", lane_ack, 1);
      lane_op(1, 16'h0888, 1, 64'hBAD);
      chk(lane_miss && !lane_ack, "R7 store unknown key miss", lane_miss, 1);
      lane_op(0, 16'h105, 7, 0);
      chk(lane_ack && lane_rdata == 64'hD000_0507, "R7 stored sector readable", lane_rdata, 64'hD000_0507);

      exp_line[0] = 26'h1000; exp_sec[0] = 3'd0; exp_dat[0] = 64'hD000_0000;
      exp_line[1] = 26'h1002; exp_sec[1] = 3'd1; exp_dat[1] = 64'hD000_0201;
      exp_line[2] = 26'h1002; exp_sec[2] = 3'd6; exp_dat[2] = 64'hD000_0206;
      exp_line[3] = 26'h1005; exp_sec[3] = 3'd7; exp_dat[3] = 64'hD000_0507;

      // R8 flush with the cache stalling at first
      wb_ready = 0;
      flush_start = 1;
      @(negedge clk);
      flush_start = 0;
      chk(flush_busy && fill_full, "R3 R8 busy and full during flush", {62'd0, flush_busy, fill_full}, 3);
      // R10 lane load that would hit, offered mid-flush
      lane_op(0, 16'h104, 0, 0);
      chk(!lane_ack && !lane_miss, "R10 lane ignored while flushing", {62'd0, lane_ack, lane_miss}, 0);
      begin
         int nb = 0;
         bit seen_done = 0;
         for (int c = 0; c < 400 && !seen_done; c++) begin
            if (flush_done) begin
               seen_done = 1;
               chk(!flush_busy, "R9 done with busy low", flush_busy, 0);
            end else begin
               if (wb_valid) begin
                  if (nb < 4) begin
                     chk(wb_line == exp_line[nb], "R8 beat line", wb_line, exp_line[nb]);
                     chk(wb_sec == exp_sec[nb], "R8 beat sector", wb_sec, exp_sec[nb]);
                     chk(wb_data == exp_dat[nb], "R8 beat data", wb_data, exp_dat[nb]);
                  end else begin
                     chk(0, "R8 extra beat", nb, 4);
                  end
               end
               wb_ready = c[0];
               if (wb_valid && wb_ready) nb++;
               @(negedge clk);
            end
         end
         chk(seen_done, "R9 flush completed", seen_done, 1);
         chk(nb == 4, "R8 beat count", nb, 4);
      end
      wb_ready = 0;
      @(negedge clk);
      chk(!flush_done, "R9 done lasts one cycle", flush_done, 0);
      chk(!fill_full, "R9 entries freed", fill_full, 0);
      lane_op(0, 16'h100, 1, 0);
      chk(lane_miss, "R9 load after flush misses", lane_miss, 1);
      // R2 allocation after flush reuses entry 0
      do_fill(16'h0200, 26'h2000, 8'h01, 40);
      lane_op(0, 16'h0200, 0, 0);
      chk(lane_ack && lane_rdata == sdat(40, 0), "R2 refill after flush", lane_rdata, sdat(40, 0));

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(PERIOD * 200000);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=hang expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule